// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm and Periodic Interrupts

This peripheral keeps wall-clock time as a day count plus hours, minutes and seconds, all advanced from a slow reference tick. The reference runs at one of three rates: 32768, 32000 or 38400 Hz. It is presented to the block as a one-cycle `ref_tick` pulse in the system clock domain. A phase accumulator makes a 512 Hz event stream whose average rate is exact for each reference. A 9-bit sub-second counter on that stream gives power-of-two rate events from 1 Hz to 512 Hz. The 1 Hz event advances the time fields, and all carries resolve on a single clock edge.

Software reaches the block through a 16-bit register bus with a word index. It can load any time field, which restarts the sub-second prescaler. It can program a match time and choose the reference rate. Rate and alarm events are collected in a status word that software clears by writing ones to it. The status word is ANDed with an enable mask and reduced to a single interrupt line.

Top module: `rtc_wallclock`

## Requirements
- R1: After reset, every register reads 0, counting is stopped and `irq` is low.
- R2: Register word indices are: 0 hour/minute, 1 seconds, 2 alarm hour/minute, 3 alarm seconds, 4 control, 5 status, 6 enable, 8 day, 9 alarm day. Unused indices read 0. Control, enable and the alarm registers read back the value written. Control bit 7 is the count enable and bits 6:5 select the reference rate (00 = 32768 Hz, 01 = 32000 Hz, 10 = 38400 Hz).
- R3: With counting enabled, seconds advance exactly once for every F reference ticks, where F is the selected rate, for each of the three selections.
- R4: Seconds roll over from 59 to 0 into minutes, minutes from 59 to 0 into hours, and hours from 23 to 0 into the day count. The day count (9 bits) wraps to 0, and all fields change on the same edge.
- R5: When control bit 7 is 0, reference ticks change neither the time nor any status flag.
- R6: Status bits 15..8 are set by 512, 256, 128, 64, 32, 16, 8 and 4 Hz events, bit 7 by 2 Hz and bit 4 by 1 Hz. Over F ticks after a restart, the 2^k Hz bit sets exactly 2^k times.
- R7: Status bit 2 sets when a seconds step makes day, hour, minute and second all equal the alarm registers.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it, so writing back a value just read clears exactly those bits.
- R9: `irq` is high exactly when status AND enable is nonzero.
- R10: A status event and a clear of the same bit in the same cycle leave the bit set.
- R11: Writing any time register loads that field and restarts the prescaler, so the next seconds step comes a full F ticks later.
- R12: Hour/minute registers pack hours in bits 15:8 and minutes in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| bus_wr | input | 1 | Register write strobe |
| bus_word | input | 4 | Register word index (byte offset / 4) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_word`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench runs with scaled reference rates of 1024, 1000 and 1200 ticks per second. The 1000 rate makes the phase accumulator carry a fractional remainder. In that mode it counts every periodic flag over one second; a wrong accumulator remainder or tap mask would give 511 or 513 events instead of 512, or the wrong power of two. It drives the clock across 23:59:59 on day 511, where a missed carry would leave a stale minute or a day that does not wrap to 0. It also places a status clear on the exact edge of a 512 Hz event, where a design that lets the clear win would lose the flag. It checks that a seconds write delays the next step by a full second; a design without the restart would step early.

// File: rtl/rtc_wallclock.sv
module rtc_wallclock #(
  parameter int unsigned FREQ0  = 32768,
  parameter int unsigned FREQ1  = 32000,
  parameter int unsigned FREQ2  = 38400,
  parameter int unsigned DAY_W  = 9,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_word,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq
);
  localparam int unsigned STEP  = 512;
  localparam int unsigned FMAX  = (FREQ0 > FREQ1) ? ((FREQ0 > FREQ2) ? FREQ0 : FREQ2)
                                                  : ((FREQ1 > FREQ2) ? FREQ1 : FREQ2);
  localparam int unsigned ACC_W = $clog2(FMAX + STEP) + 1;
  localparam logic [ADDR_W-1:0] W_HM = 0, W_SEC = 1, W_AHM = 2, W_ASEC = 3, W_CTRL = 4,
                                W_STAT = 5, W_IEN = 6, W_DAY = 8, W_ADAY = 9;

  logic [5:0] sec_q, min_q, a_sec_q, a_min_q;
  logic [4:0] hr_q, a_hr_q;
  logic [DAY_W-1:0] day_q, a_day_q;
  logic [1:0] sel_q;
  logic en_q;
  logic [15:0] status_q, ien_q;
  logic [ACC_W-1:0] acc_q, acc_sum, freq;
  logic [8:0] sub_q;

  wire wr_hm   = bus_wr && bus_word == W_HM;
  wire wr_sec  = bus_wr && bus_word == W_SEC;
  wire wr_day  = bus_wr && bus_word == W_DAY;
  wire wr_stat = bus_wr && bus_word == W_STAT;
  wire time_wr = wr_hm | wr_sec | wr_day;

  always_comb
    case (sel_q)
      2'd0:    freq = ACC_W'(FREQ0);
      2'd1:    freq = ACC_W'(FREQ1);
      default: freq = ACC_W'(FREQ2);
    endcase

  assign acc_sum = acc_q + ACC_W'(STEP);
  wire adv     = en_q & ref_tick & ~time_wr;
  wire ovf     = acc_sum >= freq;
  wire tick512 = adv & ovf;
  wire tick1   = tick512 & (&sub_q);

  logic [9:0] rate_ev;
  for (genvar r = 0; r < 9; r++) begin : g_tap
    assign rate_ev[r] = tick512 & (&sub_q[8-r:0]);
  end
  assign rate_ev[9] = tick512;

  wire sec_wrap = sec_q == 6'd59;
  wire min_wrap = min_q == 6'd59;
  wire hr_wrap  = hr_q == 5'd23;
  wire [5:0] sec_n = sec_wrap ? 6'd0 : sec_q + 6'd1;
  wire [5:0] min_n = sec_wrap ? (min_wrap ? 6'd0 : min_q + 6'd1) : min_q;
  wire [4:0] hr_n  = (sec_wrap && min_wrap) ? (hr_wrap ? 5'd0 : hr_q + 5'd1) : hr_q;
  wire [DAY_W-1:0] day_n = (sec_wrap && min_wrap && hr_wrap) ? day_q + DAY_W'(1) : day_q;

  wire alarm_ev = tick1 && {day_n, hr_n, min_n, sec_n} == {a_day_q, a_hr_q, a_min_q, a_sec_q};

  logic [15:0] ev;
  always_comb begin
    ev = 16'd0;
    ev[2] = alarm_ev;
    ev[4] = rate_ev[0];
    ev[7] = rate_ev[1];
    ev[15:8] = rate_ev[9:2];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_q <= '0;
      sub_q <= '0;
    end else if (time_wr) begin
      acc_q <= '0;
      sub_q <= '0;
    end else if (adv) begin
      acc_q <= ovf ? acc_sum - freq : acc_sum;
      if (ovf) sub_q <= sub_q + 9'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; hr_q <= '0; day_q <= '0;
    end else if (time_wr) begin
      if (wr_hm) begin
        hr_q  <= bus_wdata[12:8];
        min_q <= bus_wdata[5:0];
      end
      if (wr_sec) sec_q <= bus_wdata[5:0];
      if (wr_day) day_q <= bus_wdata[DAY_W-1:0];
    end else if (tick1) begin
      sec_q <= sec_n; min_q <= min_n; hr_q <= hr_n; day_q <= day_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sec_q <= '0; a_min_q <= '0; a_hr_q <= '0; a_day_q <= '0;
      sel_q <= '0; en_q <= 1'b0; ien_q <= '0; status_q <= '0;
    end else begin
      if (bus_wr && bus_word == W_AHM) begin
        a_hr_q  <= bus_wdata[12:8];
        a_min_q <= bus_wdata[5:0];
      end
      if (bus_wr && bus_word == W_ASEC) a_sec_q <= bus_wdata[5:0];
      if (bus_wr && bus_word == W_ADAY) a_day_q <= bus_wdata[DAY_W-1:0];
      if (bus_wr && bus_word == W_CTRL) begin
        sel_q <= bus_wdata[6:5];
        en_q  <= bus_wdata[7];
      end
      if (bus_wr && bus_word == W_IEN) ien_q <= bus_wdata;
      status_q <= (status_q & ~(wr_stat ? bus_wdata : 16'd0)) | ev;
    end

  always_comb
    case (bus_word)
      W_HM:    bus_rdata = {3'd0, hr_q, 2'd0, min_q};
      W_SEC:   bus_rdata = {10'd0, sec_q};
      W_AHM:   bus_rdata = {3'd0, a_hr_q, 2'd0, a_min_q};
      W_ASEC:  bus_rdata = {10'd0, a_sec_q};
      W_CTRL:  bus_rdata = {8'd0, en_q, sel_q, 5'd0};
      W_STAT:  bus_rdata = status_q;
      W_IEN:   bus_rdata = ien_q;
      W_DAY:   bus_rdata = 16'(day_q);
      W_ADAY:  bus_rdata = 16'(a_day_q);
      default: bus_rdata = 16'd0;
    endcase

  assign irq = |(status_q & ien_q);
endmodule

// File: rtl/rtc_wallclock_chk.sv
module rtc_wallclock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_stat,
  input logic        time_wr,
  input logic [15:0] bus_wdata,
  input logic        irq,
  input logic [15:0] ien_q,
  input logic [15:0] status_q,
  input logic        tick512,
  input logic        tick1,
  input logic        alarm_ev,
  input logic        en_q,
  input logic [5:0]  sec_q,
  input logic [5:0]  min_q,
  input logic [4:0]  hr_q
);
  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tick512 |=> status_q[15]);

  assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[2] && !alarm_ev) |=> !status_q[2]);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && status_q[4]) |=> status_q[4]);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == 16'd0) |-> !irq);

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !time_wr) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick1 && sec_q == 6'd59) |=> sec_q == 6'd0);
endmodule

bind rtc_wallclock rtc_wallclock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .time_wr(time_wr),
  .bus_wdata(bus_wdata), .irq(irq), .ien_q(ien_q), .status_q(status_q),
  .tick512(tick512), .tick1(tick1), .alarm_ev(alarm_ev), .en_q(en_q),
  .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q)
);

// File: tb/test_rtc_wallclock.sv
`timescale 1ns/1ps
module test_rtc_wallclock;
  localparam int F0 = 1024, F1 = 1000, F2 = 1200;
  logic clk = 0, rst_n = 0, ref_tick = 0, bus_wr = 0;
  logic [3:0] bus_word = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int total = 0, bad = 0;

  rtc_wallclock #(.FREQ0(F0), .FREQ1(F1), .FREQ2(F2)) i_rtc_wallclock (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] w, input logic [15:0] d);
    @(negedge clk) begin bus_wr = 1; bus_word = w; bus_wdata = d; end
    @(negedge clk) bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] w, output logic [15:0] d);
    @(negedge clk) bus_word = w;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_tick = 1;
      @(negedge clk) ref_tick = 0;
    end
  endtask

  task automatic count_flags(input logic [15:0] mask, input int n, output int cnt);
    wr(5, 16'hFFFF); wr(6, mask); wr(1, 0);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin ref_tick = 1; bus_wr = 0; end
      @(negedge clk) ref_tick = 0;
      if (irq) begin cnt++; bus_wr = 1; bus_word = 5; bus_wdata = mask; end
    end
    @(negedge clk) bus_wr = 0;
  endtask

  initial begin
    #900000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int cnt;
    int freqs[3];
    freqs[0] = F0; freqs[1] = F1; freqs[2] = F2;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int w = 0; w < 16; w++) begin
      rd(4'(w), v);
      check($sformatf("R1 reg %0d", w), v, 0);
    end
    check("R1 irq", irq, 0);

    // R2 readback and map
    wr(4, 16'h00A0); rd(4, v); check("R2 ctrl", v, 16'h00A0);
    wr(6, 16'h1234); rd(6, v); check("R2 enable", v, 16'h1234);
    wr(3, 16'd33);   rd(3, v); check("R2 alarm sec", v, 16'd33);
    wr(9, 16'd300);  rd(9, v); check("R2 alarm day", v, 16'd300);
    wr(7, 16'hFFFF); rd(7, v); check("R2 unused index", v, 0);
    // R12 packing
    wr(2, 16'h1711); rd(2, v); check("R12 alarm hm", v, 16'h1711);
    wr(0, 16'h0C2D); rd(0, v); check("R12 hm", v, 16'h0C2D);
    wr(6, 0);

    // R3 / R11 exact second per selection, restart on write
    for (int s = 0; s < 3; s++) begin
      wr(4, 16'(8'h80 | (s << 5)));
      wr(1, 16'd10);
      ticks(freqs[s] / 2);
      wr(1, 16'd20);
      ticks(freqs[s] - 1);
      rd(1, v); check($sformatf("R11 sel%0d no early step", s), v, 20);
      ticks(1);
      rd(1, v); check($sformatf("R3 sel%0d step", s), v, 21);
    end

    // R4 carries and wraps
    wr(4, 16'h0080);
    wr(8, 16'd511); wr(0, 16'h173B); wr(1, 16'd59);
    ticks(F0);
    rd(0, v); check("R4 hm wrap", v, 0);
    rd(1, v); check("R4 sec wrap", v, 0);
    rd(8, v); check("R4 day wrap", v, 0);
    wr(0, 16'h0A3B); wr(1, 16'd59); ticks(F0);
    rd(0, v); check("R4 hour carry", v, 16'h0B00);
    wr(0, 16'h0507); wr(1, 16'd59); ticks(F0);
    rd(0, v); check("R4 minute carry", v, 16'h0508);

    // R5 freeze
    wr(4, 16'h0000); wr(5, 16'hFFFF); wr(1, 16'd5);
    ticks(2 * F0);
    rd(1, v); check("R5 sec frozen", v, 5);
    rd(5, v); check("R5 no flags", v, 0);

    // R6 periodic flag counts on the fractional rate
    wr(4, 16'h00A0);
    for (int k = 0; k < 10; k++) begin
      logic [15:0] m;
      m = (k == 0) ? 16'h0010 : (k == 1) ? 16'h0080 : 16'(1 << (k + 6));
      count_flags(m, F1, cnt);
      check($sformatf("R6 sel1 %0d Hz", 1 << k), cnt, 1 << k);
    end
    wr(4, 16'h0080);
    count_flags(16'h8000, F0, cnt); check("R6 sel0 512 Hz", cnt, 512);
    count_flags(16'h0010, F0, cnt); check("R6 sel0 1 Hz", cnt, 1);
    wr(4, 16'h00C0);
    count_flags(16'h8000, F2, cnt); check("R6 sel2 512 Hz", cnt, 512);
    count_flags(16'h0010, F2, cnt); check("R6 sel2 1 Hz", cnt, 1);

    // R7 alarm
    wr(4, 16'h0080); wr(6, 0);
    wr(9, 16'd3); wr(2, 16'h0A15); wr(3, 16'd0);
    wr(8, 16'd3); wr(0, 16'h0A14); wr(1, 16'd58);
    wr(5, 16'hFFFF);
    ticks(F0);
    rd(5, v); check("R7 not yet", v[2], 0);
    ticks(F0);
    rd(5, v); check("R7 alarm set", v[2], 1);
    wr(6, 16'h0004); check("R9 irq on alarm", irq, 1);
    wr(5, 16'h0004); check("R8 alarm cleared irq", irq, 0);

    // R10 set wins: second tick after restart is a 512 Hz event
    wr(6, 0); wr(5, 16'hFFFF); wr(1, 0);
    ticks(1);
    @(negedge clk) begin ref_tick = 1; bus_wr = 1; bus_word = 5; bus_wdata = 16'h8000; end
    @(negedge clk) begin ref_tick = 0; bus_wr = 0; end
    rd(5, v); check("R10 set beats clear", v, 16'h8000);

    // R8 write-zero keeps, write-back clears exactly
    wr(5, 16'h0000); rd(5, v); check("R8 zero write keeps", v, 16'h8000);
    wr(1, 0); ticks(4);
    rd(5, v); check("R8 several flags", v, 16'hC000);
    wr(5, 16'h4000); rd(5, v); check("R8 partial clear", v, 16'h8000);
    wr(5, v); rd(5, v); check("R8 write-back clears", v, 0);

    // R9 masking
    wr(1, 0); ticks(2);
    wr(6, 16'h0000); check("R9 masked", irq, 0);
    wr(6, 16'h0004); check("R9 other bit", irq, 0);
    wr(6, 16'h8000); check("R9 enabled", irq, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule